// File: doc/BRIEF.md
# Step-Adaptive Second-Stage Averaging Filter

This block sits behind a first-stage decimation filter and turns its sample stream, one sample per strobe, into results. In its normal mode each result is the mean of the newest sixteen samples. When fast-step tracking is enabled, every incoming sample is compared with the sample that arrived two strobes before it. A difference larger than one percent of full scale is treated as a step in the input. The block then drops to a very short average, so the result follows the new level almost at once. After the input settles, the average is lengthened in stages until the block hands control back to the sixteen-sample average.

A bypass setting passes each first-stage sample through unchanged. When bypass and chopping are both on, consecutive results come from opposite chop polarities. A phase bit marks each result so that a consumer can combine them in pairs. A status flag reports that the block is in the step-tracking schedule rather than in normal mode.

Samples and results are 24-bit two's complement, and the history depth must be a power of two of at least 16. Each result appears one clock after the strobe of the sample that produced it.

Top module: `step_avg_filter`

## Requirements
- R1: After reset, `res_valid`, `res_data`, `settling` and `pair_phase` are 0, and the sample history holds zeros.
- R2: `res_valid` is high for exactly the one cycle after each cycle with `smp_valid` high, and low otherwise. The history changes only on a strobe.
- R3: In normal mode the result is the sum of the newest 16 samples (the current one included, with zeros for history not yet filled since reset) shifted right arithmetically by 4, which is the mean rounded toward minus infinity.
- R4: With `fast_step_en` at 0, every sample, large steps included, gets the normal result and `settling` is 0 after that sample.
- R5: A step is a sample whose absolute difference from the sample two strobes earlier is strictly greater than THRESH = FULL_SCALE/100 (integer division, 83886 by default). Only a sample with at least two earlier samples since reset counts. A difference of exactly THRESH is not a step.
- R6: For a step sample (with fast-step on and bypass off), the result is the sample itself when `chop_en` is 0, and the floor mean of the newest 2 samples when `chop_en` is 1. `settling` becomes 1. The block stays at this length for as long as each new sample is a step.
- R7: After the last step sample, the following non-step samples get 2 results with a 2-sample mean, then 4 with a 4-sample mean, then 8 with an 8-sample mean, then 6 with a 16-sample mean. `settling` stays 1 through these 20 results. From the 21st result on, the block is in normal mode with `settling` at 0.
- R8: A step during any part of the lengthening schedule restarts it at the initial length of R6.
- R9: With `bypass_en` at 1, `res_data` equals the sample unchanged, `settling` becomes 0 and any schedule in progress is abandoned.
- R10: While `chop_en` and `bypass_en` are both 1, `pair_phase` is 0 on the first result and alternates on each later result. On any result produced with either of them at 0, `pair_phase` is 0, and the alternation starts again at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Strobe for a first-stage sample |
| smp_data | input | 24 | First-stage sample, two's complement |
| fast_step_en | input | 1 | Enables step detection and adaptive averaging |
| bypass_en | input | 1 | Passes samples through without averaging |
| chop_en | input | 1 | Chopping active: sets the initial length and pairing |
| res_valid | output | 1 | Result strobe, one cycle after `smp_valid` |
| res_data | output | 24 | Result, two's complement |
| settling | output | 1 | 1 while the step-tracking schedule is active |
| pair_phase | output | 1 | Chop polarity marker for bypassed results |

## Verification
The hardest situations to reach are the exit from the 16-sample stage, a re-trigger in the middle of the schedule, and a difference that sits exactly on the threshold. Each needs a precise count of quiet samples, or a carefully shaped sample pair two strobes apart. Directed sequences hold the input constant for exactly the needed number of strobes. They restart the schedule after a few settled samples and step by THRESH and THRESH+1 against the sample two back. A long random phase then mixes noise, jumps, idle cycles and control changes. A behavioural model tracks the remaining outputs per stage and is compared with the outputs on every clock.

// File: rtl/step_avg_pkg.sv
package step_avg_pkg;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_AVG2  = 3'd1,
    ST_AVG4  = 3'd2,
    ST_AVG8  = 3'd3,
    ST_AVG16 = 3'd4
  } stage_e;

  localparam int unsigned RUN_AVG2  = 2;
  localparam int unsigned RUN_AVG4  = 4;
  localparam int unsigned RUN_AVG8  = 8;
  localparam int unsigned RUN_AVG16 = 6;

  // number of results produced in a lengthening stage before moving on
  function automatic logic [4:0] stage_run(input stage_e s);
    case (s)
      ST_AVG2:  return 5'(RUN_AVG2);
      ST_AVG4:  return 5'(RUN_AVG4);
      ST_AVG8:  return 5'(RUN_AVG8);
      ST_AVG16: return 5'(RUN_AVG16);
      default:  return 5'd0;
    endcase
  endfunction

  // log2 of the averaging length used in a lengthening stage
  function automatic logic [2:0] stage_log2(input stage_e s);
    case (s)
      ST_AVG2:  return 3'd1;
      ST_AVG4:  return 3'd2;
      ST_AVG8:  return 3'd3;
      ST_AVG16: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic stage_e stage_after(input stage_e s);
    case (s)
      ST_HOLD: return ST_AVG2;
      ST_AVG2: return ST_AVG4;
      ST_AVG4: return ST_AVG8;
      default: return ST_AVG16;
    endcase
  endfunction

endpackage

// File: rtl/step_avg_hist.sv
module step_avg_hist #(
  parameter int DW    = 24,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  output logic [DEPTH-1:0][DW-1:0]   win,
  output logic                       primed
);

  logic [1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win    <= '0;
      fill_q <= 2'd0;
    end else if (push) begin
      win <= {win[DEPTH-2:0], din};
      if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
    end
  end

  assign primed = (fill_q == 2'd2);

  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(win));

  p_hist_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> win[0] == $past(din));

endmodule

// File: rtl/step_avg_sched.sv
module step_avg_sched
  import step_avg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       fast_en,
  input  logic       bypass_en,
  input  logic       chop_en,
  input  logic       exceed,
  output logic       use_norm,
  output logic [2:0] sel_log2,
  output logic       active
);

  logic       active_q, active_d;
  stage_e     stage_q, stage_d;
  logic [4:0] used_q, used_d;

  always_comb begin
    active_d = active_q;
    stage_d  = stage_q;
    used_d   = used_q;
    if (bypass_en || !fast_en) begin
      active_d = 1'b0;
      stage_d  = ST_HOLD;
      used_d   = 5'd0;
    end else if (exceed) begin
      active_d = 1'b1;
      stage_d  = ST_HOLD;
      used_d   = 5'd0;
    end else if (active_q) begin
      if (stage_q == ST_HOLD) begin
        stage_d = ST_AVG2;
        used_d  = 5'd1;
      end else if (used_q == stage_run(stage_q)) begin
        if (stage_q == ST_AVG16) begin
          active_d = 1'b0;
          stage_d  = ST_HOLD;
          used_d   = 5'd0;
        end else begin
          stage_d = stage_after(stage_q);
          used_d  = 5'd1;
        end
      end else begin
        used_d = used_q + 5'd1;
      end
    end
  end

  assign use_norm = !active_d;
  assign sel_log2 = (stage_d == ST_HOLD) ? (chop_en ? 3'd1 : 3'd0) : stage_log2(stage_d);
  assign active   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      stage_q  <= ST_HOLD;
      used_q   <= 5'd0;
    end else if (strobe) begin
      active_q <= active_d;
      stage_q  <= stage_d;
      used_q   <= used_d;
    end
  end

  p_run_in_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && stage_q != ST_HOLD) |-> (used_q >= 5'd1 && used_q <= stage_run(stage_q)));

  p_exit_from_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(stage_q) == ST_AVG16 || $past(bypass_en) || !$past(fast_en)));

  p_idle_when_normal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (stage_q == ST_HOLD));

endmodule

// File: rtl/step_avg_filter.sv
module step_avg_filter
  import step_avg_pkg::*;
#(
  parameter int DW         = 24,
  parameter int DEPTH      = 16,
  parameter int FULL_SCALE = 8388607
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          fast_step_en,
  input  logic          bypass_en,
  input  logic          chop_en,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          settling,
  output logic          pair_phase
);

  localparam int NORM_LOG2 = $clog2(DEPTH);
  localparam int SW        = DW + NORM_LOG2;
  localparam int IW        = NORM_LOG2;
  localparam logic [DW:0] THRESH = (DW+1)'(FULL_SCALE / 100);

  function automatic logic signed [SW-1:0] widen(input logic [DW-1:0] v);
    return {{(SW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic beyond_thresh(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    logic [DW:0] mag;
    d   = {a[DW-1], a} - {b[DW-1], b};
    mag = d[DW] ? (~d + 1'b1) : d;
    return mag > THRESH;
  endfunction

  function automatic logic [DW-1:0] pow2_mean(input logic signed [SW-1:0] s, input logic [2:0] lg);
    logic signed [SW-1:0] q;
    q = s >>> lg;
    return q[DW-1:0];
  endfunction

  logic [DEPTH-1:0][DW-1:0] win;
  logic                     primed;

  step_avg_hist #(.DW(DW), .DEPTH(DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (smp_valid),
    .din    (smp_data),
    .win    (win),
    .primed (primed)
  );

  logic step_hit;
  assign step_hit = primed && beyond_thresh(smp_data, win[1]);

  logic       use_norm;
  logic [2:0] sel_log2;

  step_avg_sched u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (smp_valid),
    .fast_en   (fast_step_en),
    .bypass_en (bypass_en),
    .chop_en   (chop_en),
    .exceed    (step_hit),
    .use_norm  (use_norm),
    .sel_log2  (sel_log2),
    .active    (settling)
  );

  // running sums over the window that includes the incoming sample
  logic signed [SW-1:0] psum [DEPTH];
  always_comb begin
    psum[0] = widen(smp_data);
    for (int k = 1; k < DEPTH; k++) psum[k] = psum[k-1] + widen(win[k-1]);
  end

  logic [2:0]    avg_log2;
  logic [IW-1:0] sum_idx;
  logic [DW-1:0] avg_val;
  assign avg_log2 = use_norm ? 3'(NORM_LOG2) : sel_log2;
  assign sum_idx  = IW'((32'd1 << avg_log2) - 32'd1);
  assign avg_val  = pow2_mean(psum[sum_idx], avg_log2);

  logic pair_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      pair_phase <= 1'b0;
      pair_q     <= 1'b0;
    end else begin
      res_valid <= smp_valid;
      if (smp_valid) begin
        res_data <= bypass_en ? smp_data : avg_val;
        if (chop_en && bypass_en) begin
          pair_phase <= pair_q;
          pair_q     <= ~pair_q;
        end else begin
          pair_phase <= 1'b0;
          pair_q     <= 1'b0;
        end
      end
    end
  end

  p_result_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> res_valid);

  p_no_spurious_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !res_valid);

  p_bypass_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bypass_en) |=> (res_data == $past(smp_data) && !settling));

  p_fast_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !fast_step_en) |=> !settling);

  p_step_raises_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fast_step_en && !bypass_en && step_hit) |=> settling);

  p_pair_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !(chop_en && bypass_en)) |=> !pair_phase);

endmodule

// File: tb/step_avg_filter_test.sv
module step_avg_filter_test;

  localparam int FS   = 8388607;
  localparam int THR  = FS / 100;
  localparam int HLEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        fast_step_en = 1'b0;
  logic        bypass_en = 1'b0;
  logic        chop_en = 1'b0;
  logic        res_valid;
  logic [23:0] res_data;
  logic        settling;
  logic        pair_phase;

  always #2.5 clk = ~clk;

  step_avg_filter uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .fast_step_en(fast_step_en), .bypass_en(bypass_en), .chop_en(chop_en),
    .res_valid(res_valid), .res_data(res_data), .settling(settling), .pair_phase(pair_phase)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int    hist[$];
  int    seen = 0;
  bit    m_act = 0;
  int    m_stage = 0;
  int    m_left = 0;
  bit    m_ph = 0;
  bit    e_valid = 0;
  int    e_data = 0;
  bit    e_flag = 0;
  bit    e_pair = 0;
  string e_tag = "R1";

  task automatic chk(bit ok, string tag, string what, longint got, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int floor_mean(int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += hist[i];
    if (s >= 0) return int'(s / n);
    return -int'((-s + n - 1) / n);
  endfunction

  function automatic int stage_len(int s);
    case (s)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int stage_count(int s);
    case (s)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 6;
    endcase
  endfunction

  task automatic model(int x, bit f, bit b, bit c);
    longint diff;
    bit     big;
    bit     was_sched;
    diff = (seen >= 2) ? longint'(x) - longint'(hist[1]) : 0;
    if (diff < 0) diff = -diff;
    big = (seen >= 2) && (diff > THR);
    was_sched = m_act && (m_stage > 0);
    hist.push_front(x);
    void'(hist.pop_back());
    if (seen < 2) seen++;
    if (b) begin
      m_act = 0; m_stage = 0; e_data = x; e_tag = "R9";
    end else if (!f) begin
      m_act = 0; m_stage = 0; e_data = floor_mean(HLEN); e_tag = "R4";
    end else if (big) begin
      m_act = 1; m_stage = 0;
      e_data = c ? floor_mean(2) : x;
      e_tag = was_sched ? "R8" : "R6";
    end else begin
      if (m_act) begin
        if (m_stage == 0) begin
          m_stage = 1; m_left = stage_count(1);
        end else if (m_left == 0) begin
          m_stage++;
          if (m_stage > 4) begin m_act = 0; m_stage = 0; end
          else m_left = stage_count(m_stage);
        end
      end
      if (m_act) begin
        e_data = floor_mean(stage_len(m_stage)); m_left--; e_tag = "R7";
      end else begin
        e_data = floor_mean(HLEN);
        e_tag = (seen >= 2 && diff == THR) ? "R5" : "R3";
      end
    end
    e_flag = m_act;
    if (c && b) begin e_pair = m_ph; m_ph = ~m_ph; end
    else begin e_pair = 0; m_ph = 0; end
    e_valid = 1;
  endtask

  task automatic compare();
    int got;
    got = $signed(res_data);
    chk(res_valid === e_valid, "R2", "res_valid", res_valid, e_valid);
    chk(settling === e_flag, e_tag, "settling", settling, e_flag);
    if (e_valid) begin
      chk(got == e_data, e_tag, "res_data", got, e_data);
      chk(pair_phase === e_pair, "R10", "pair_phase", pair_phase, e_pair);
    end
  endtask

  task automatic cyc(bit v, int x, bit f, bit b, bit c);
    @(negedge clk);
    compare();
    fast_step_en = f; bypass_en = b; chop_en = c;
    smp_valid = v;
    smp_data = x[23:0];
    if (v) model(x, f, b, c);
    else e_valid = 0;
  endtask

  task automatic run(int n, int x, bit f, bit b, bit c);
    for (int i = 0; i < n; i++) cyc(1'b1, x, f, b, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < HLEN; i++) hist.push_back(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_valid === 1'b0, "R1", "res_valid", res_valid, 0);
    chk(res_data === 24'd0, "R1", "res_data", res_data, 0);
    chk(settling === 1'b0, "R1", "settling", settling, 0);
    chk(pair_phase === 1'b0, "R1", "pair_phase", pair_phase, 0);
    rst_n = 1'b1;

    // R3 / R4: normal averaging, steps ignored with fast-step off
    for (int i = 0; i < 20; i++) cyc(1'b1, 1000 * i - 7000, 0, 0, 1);
    cyc(1'b0, 0, 0, 0, 1);
    run(5, 3000000, 0, 0, 1);
    run(3, -2500000, 0, 0, 0);
    run(20, 500, 0, 0, 1);

    // R6 / R7: step with chop, held while still stepping, then full schedule
    run(18, 500, 1, 0, 1);
    cyc(1'b1, 2000000, 1, 0, 1);
    for (int i = 1; i <= 3; i++) cyc(1'b1, 2000000 + 300000 * i, 1, 0, 1);
    for (int i = 0; i < 25; i++) begin
      cyc(1'b1, 2900000 + (i % 3), 1, 0, 1);
      if (i % 7 == 3) cyc(1'b0, 0, 1, 0, 1);
    end

    // R8: restart mid-schedule
    run(1, -1500000, 1, 0, 1);
    run(6, -1500000, 1, 0, 1);
    run(1, 100000, 1, 0, 1);
    run(12, 100000, 1, 0, 1);
    run(1, 900000, 1, 0, 1);
    run(25, 900000, 1, 0, 1);

    // R6: chop off starts at a single-sample result
    run(3, 4000000, 1, 0, 0);
    run(25, 4000000, 1, 0, 0);

    // R5: threshold boundary, positive and negative
    run(25, 1000, 1, 0, 1);
    run(2, 1000 + THR, 1, 0, 1);
    run(1, 1000 + 2 * THR + 1, 1, 0, 1);
    run(25, 1000 + 2 * THR + 1, 1, 0, 1);
    run(2, 1000 + THR + 1, 1, 0, 1);
    run(2, 1000, 1, 0, 1);
    run(1, 1000 - THR - 1, 1, 0, 1);
    run(25, 1000 - THR - 1, 1, 0, 1);

    // R9 / R10: bypass with and without chop, abandoning a schedule
    run(1, 6000000, 1, 0, 1);
    for (int i = 0; i < 9; i++) begin
      cyc(1'b1, -300 * i, 1, 1, 1);
      if (i == 4) cyc(1'b0, 0, 1, 1, 1);
    end
    run(3, 77, 1, 1, 0);
    run(4, -8000000, 0, 1, 1);
    run(20, 12345, 1, 0, 1);

    // mixed random traffic
    begin
      int base = 0;
      bit f = 1, b = 0, c = 1;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 19) == 0) base = $urandom_range(0, 14000000) - 7000000;
        if ($urandom_range(0, 49) == 0) f = ~f;
        if ($urandom_range(0, 79) == 0) b = ~b;
        if ($urandom_range(0, 49) == 0) c = ~c;
        cyc($urandom_range(0, 3) != 0, base + $urandom_range(0, 2 * THR) - THR, f, b, c);
      end
    end

    cyc(1'b0, 0, 1, 0, 1);
    cyc(1'b0, 0, 1, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule